// File: doc/BRIEF.md
# Oscillator Failure Clock Monitor

This block watches a primary oscillator clock with the help of a second, free-running backup clock that does not depend on it. A divided copy of the primary clock is brought into the backup domain through a synchronizer, and every transition seen there restarts a timeout counter. If the counter runs out because no primary transition arrived, the block latches a failure. It then raises a level interrupt and moves the CPU clock output from the primary clock to the backup clock without producing short pulses.

The failure state is sticky. A primary clock that starts up again does not bring the CPU clock back. Only a hardware reset, or pulling the enable pin low, releases it. When the enable pin is low, supervision and the interrupt are both switched off and the CPU clock output carries the primary clock directly. The interrupt stays asserted until software acknowledges it, and it is not raised again while the same failure is still latched. A status output shows which source drives the CPU clock.

Top module: `osc_clk_monitor`

## Requirements
- R1: While `rst_n_i` is low (both clocks running), `irq_o` and `sel_bak_o` are 0 and `cpu_clk_o` equals `clk_pri_i`.
- R2: While the primary clock toggles steadily (its divided transitions arriving well inside `FAIL_THRESH` backup cycles), no failure is declared: `irq_o` and `sel_bak_o` stay 0 and `cpu_clk_o` equals `clk_pri_i`.
- R3: If the primary clock stops, whether held high or held low, while `mon_en_i` is 1, then `irq_o` and `sel_bak_o` both become 1 within `FAIL_THRESH + 8` backup cycles. Neither rises in the first 4 backup cycles after the stop.
- R4: While `sel_bak_o` is 1 and `mon_en_i` is 1, `cpu_clk_o` equals `clk_bak_i`.
- R5: Once `sel_bak_o` is 1, a primary clock that resumes leaves `sel_bak_o` at 1 and `cpu_clk_o` on the backup clock. A hardware reset, or `mon_en_i` low, returns `cpu_clk_o` to the primary clock.
- R6: `irq_o` is a level. It stays 1 until `irq_ack_i` is sampled 1 on a rising backup edge, is then 0 from the following cycle, and does not return while the failure stays latched.
- R7: With `mon_en_i` at 0, `cpu_clk_o` equals `clk_pri_i` at once. Within 4 backup cycles, `irq_o` and `sel_bak_o` are 0 and any latched failure is cleared. A primary clock that stops while the pin is low causes neither an interrupt nor a switch.
- R8: With `mon_en_i` at 1, every high or low phase of `cpu_clk_o` lasts at least the shorter half period of the two input clocks, including across a switchover from a primary clock stopped high or stopped low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri_i | input | 1 | Primary oscillator clock under supervision |
| clk_bak_i | input | 1 | Independent free-running backup clock |
| rst_n_i | input | 1 | Hardware reset, active low, synchronous in each clock domain |
| mon_en_i | input | 1 | Monitor enable pin; low disables supervision and interrupt |
| irq_ack_i | input | 1 | Interrupt acknowledge, synchronous to `clk_bak_i` |
| cpu_clk_o | output | 1 | Selected CPU clock |
| irq_o | output | 1 | Clock failure interrupt request (level) |
| sel_bak_o | output | 1 | Status: 1 when the backup clock drives `cpu_clk_o` |

## Verification
The bench stops the primary clock once in its high phase and once in its low phase. A switch that assumed one stopping level would leave `cpu_clk_o` stuck or cut a runt pulse, and a pulse-width monitor catches either. After the switch it restarts the primary clock and expects the backup clock to stay selected, which exposes a design that re-arms from live edges instead of latching. It acknowledges the interrupt and then waits through the still-latched failure, which catches a level that drops without an acknowledge or fires again. It also drops the enable pin both on a healthy clock and on a failed one, so a design that still switches, or keeps the backup selected while disabled, shows a `cpu_clk_o` that does not match the primary clock.

// File: rtl/osc_mon_pkg.sv
// Package: shared constants and helpers for the oscillator failure monitor.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package osc_mon_pkg;

    // Smallest synchronizer depth that is safe for a clock crossing.
    localparam int unsigned OSC_SYNC_MIN = 2;

    // Width of a counter that must be able to hold the value lim.
    function automatic int unsigned osc_cnt_w(input int unsigned lim);
        int unsigned w;
        w = 1;
        while ((1 << w) <= lim) w++;
        return w;
    endfunction

endpackage

// File: rtl/osc_edge_sense.sv
// Module: osc_edge_sense
// Divides the primary clock in its own domain and carries the top bit of
// that divider into the backup domain through a synchronizer. Each change
// of the synchronized bit gives a single-cycle pulse on edge_o.
// Assumes: the primary clock divided by 2**PRI_DIV_W toggles more slowly
// than half the backup clock rate; SYNC_STAGES >= 2.
module osc_edge_sense
    import osc_mon_pkg::*;
#(
    parameter int unsigned PRI_DIV_W   = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_pri_i,
    input  logic clk_bak_i,
    input  logic rst_n_i,
    output logic edge_o
);

    localparam int unsigned STAGES = (SYNC_STAGES < OSC_SYNC_MIN) ? OSC_SYNC_MIN : SYNC_STAGES;

    logic [PRI_DIV_W-1:0] div_q;
    logic [STAGES-1:0]    sync_q;
    logic                 last_q;

    // Free-running divider in the primary domain; its MSB is the crossing bit.
    always_ff @(posedge clk_pri_i) begin
        if (!rst_n_i) div_q <= '0;
        else          div_q <= div_q + 1'b1;
    end

    // Synchronizer chain in the backup domain, one flop per stage.
    for (genvar s = 0; s < STAGES; s++) begin : g_sync
        if (s == 0) begin : g_first
            always_ff @(posedge clk_bak_i) begin
                if (!rst_n_i) sync_q[0] <= 1'b0;
                else          sync_q[0] <= div_q[PRI_DIV_W-1];
            end
        end else begin : g_next
            always_ff @(posedge clk_bak_i) begin
                if (!rst_n_i) sync_q[s] <= 1'b0;
                else          sync_q[s] <= sync_q[s-1];
            end
        end
    end

    // Holds the previous synchronized value for change detection.
    always_ff @(posedge clk_bak_i) begin
        if (!rst_n_i) last_q <= 1'b0;
        else          last_q <= sync_q[STAGES-1];
    end

    // A change in either direction counts as a primary transition.
    always_comb edge_o = sync_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/osc_fail_timer.sv
// Module: osc_fail_timer
// Backup-domain timeout. The counter clears on every primary transition and
// saturates at FAIL_THRESH; reaching it latches the failure and sets the
// interrupt level. The interrupt clears on acknowledge. The enable pin is
// synchronized here, and while it is low all state is held cleared.
// Assumes: irq_ack_i is synchronous to clk_bak_i.
module osc_fail_timer
    import osc_mon_pkg::*;
#(
    parameter int unsigned FAIL_THRESH = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_bak_i,
    input  logic rst_n_i,
    input  logic mon_en_i,
    input  logic edge_i,
    input  logic irq_ack_i,
    output logic mon_on_o,
    output logic fail_o,
    output logic irq_o
);

    localparam int unsigned STAGES = (SYNC_STAGES < OSC_SYNC_MIN) ? OSC_SYNC_MIN : SYNC_STAGES;
    localparam int unsigned CNT_W  = osc_cnt_w(FAIL_THRESH);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FAIL_THRESH);

    logic [STAGES-1:0] en_sync_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              fail_q;
    logic              irq_q;
    logic              expired;

    // Brings the asynchronous enable pin into the backup domain.
    always_ff @(posedge clk_bak_i) begin
        if (!rst_n_i) en_sync_q <= '0;
        else          en_sync_q <= {en_sync_q[STAGES-2:0], mon_en_i};
    end

    assign mon_on_o = en_sync_q[STAGES-1];
    assign expired  = (cnt_q == LIMIT);

    // Timeout counter: restarts on a primary transition, holds at the limit.
    always_ff @(posedge clk_bak_i) begin
        if (!rst_n_i || !mon_on_o) cnt_q <= '0;
        else if (edge_i)           cnt_q <= '0;
        else if (!expired)         cnt_q <= cnt_q + 1'b1;
    end

    // Sticky failure latch and interrupt level with acknowledge.
    always_ff @(posedge clk_bak_i) begin
        if (!rst_n_i || !mon_on_o) begin
            fail_q <= 1'b0;
            irq_q  <= 1'b0;
        end else if (expired && !fail_q) begin
            fail_q <= 1'b1;
            irq_q  <= 1'b1;
        end else if (irq_ack_i) begin
            irq_q  <= 1'b0;
        end
    end

    assign fail_o = fail_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/osc_clk_switch.sv
// Module: osc_clk_switch
// Glitch-free two-source clock switch. Each source has a gate flop on its
// own falling edge. The primary gate re-opens only after the failure and
// the backup gate have both been seen low in the primary domain. A latched
// failure, or an open backup gate, forces the primary path off, because a
// dead primary clock cannot clock its own gate flop. With the enable pin
// low, the output is the raw primary clock.
// Assumes: fail_i is a flop output in the backup domain.
module osc_clk_switch
    import osc_mon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_pri_i,
    input  logic clk_bak_i,
    input  logic rst_n_i,
    input  logic mon_en_i,
    input  logic fail_i,
    output logic cpu_clk_o,
    output logic sel_bak_o
);

    localparam int unsigned STAGES = (SYNC_STAGES < OSC_SYNC_MIN) ? OSC_SYNC_MIN : SYNC_STAGES;

    logic [STAGES-1:0] fail_ps_q;
    logic [STAGES-1:0] bak_ps_q;
    logic              pri_gate_q;
    logic              bak_gate_q;
    logic              pri_on;
    logic              gated_clk;

    // Primary domain: synchronize the status bits and drive the primary gate.
    always_ff @(negedge clk_pri_i) begin
        if (!rst_n_i) begin
            fail_ps_q  <= '0;
            bak_ps_q   <= '0;
            pri_gate_q <= 1'b1;
        end else begin
            fail_ps_q  <= {fail_ps_q[STAGES-2:0], fail_i};
            bak_ps_q   <= {bak_ps_q[STAGES-2:0], bak_gate_q};
            pri_gate_q <= !fail_ps_q[STAGES-1] && !bak_ps_q[STAGES-1];
        end
    end

    // Backup domain: the backup gate opens on its falling edge after a failure.
    always_ff @(negedge clk_bak_i) begin
        if (!rst_n_i) bak_gate_q <= 1'b0;
        else          bak_gate_q <= fail_i;
    end

    // The primary path is only on while no failure and no backup gate exist.
    always_comb pri_on = pri_gate_q && !fail_i && !bak_gate_q;

    // Output combine of the two gated sources, bypassed when disabled.
    always_comb begin
        gated_clk = (clk_pri_i & pri_on) | (clk_bak_i & bak_gate_q);
        cpu_clk_o = mon_en_i ? gated_clk : clk_pri_i;
    end

    assign sel_bak_o = bak_gate_q;

endmodule

// File: rtl/osc_clk_monitor.sv
// Module: osc_clk_monitor (top)
// Oscillator failure clock monitor. It detects missing primary transitions
// with a backup-domain timeout, latches the failure until reset or disable,
// raises a level interrupt, and moves the CPU clock to the backup source.
// Assumes: both clocks run while rst_n_i is low for several cycles of each.
module osc_clk_monitor #(
    parameter int unsigned PRI_DIV_W   = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FAIL_THRESH = 8
) (
    input  logic clk_pri_i,
    input  logic clk_bak_i,
    input  logic rst_n_i,
    input  logic mon_en_i,
    input  logic irq_ack_i,
    output logic cpu_clk_o,
    output logic irq_o,
    output logic sel_bak_o
);

    logic edge_w;
    logic mon_on_w;
    logic fail_w;

    osc_edge_sense #(
        .PRI_DIV_W   (PRI_DIV_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) sense_i (
        .clk_pri_i (clk_pri_i),
        .clk_bak_i (clk_bak_i),
        .rst_n_i   (rst_n_i),
        .edge_o    (edge_w)
    );

    osc_fail_timer #(
        .FAIL_THRESH (FAIL_THRESH),
        .SYNC_STAGES (SYNC_STAGES)
    ) timer_i (
        .clk_bak_i (clk_bak_i),
        .rst_n_i   (rst_n_i),
        .mon_en_i  (mon_en_i),
        .edge_i    (edge_w),
        .irq_ack_i (irq_ack_i),
        .mon_on_o  (mon_on_w),
        .fail_o    (fail_w),
        .irq_o     (irq_o)
    );

    osc_clk_switch #(
        .SYNC_STAGES (SYNC_STAGES)
    ) switch_i (
        .clk_pri_i (clk_pri_i),
        .clk_bak_i (clk_bak_i),
        .rst_n_i   (rst_n_i),
        .mon_en_i  (mon_en_i),
        .fail_i    (fail_w),
        .cpu_clk_o (cpu_clk_o),
        .sel_bak_o (sel_bak_o)
    );

endmodule

// File: rtl/osc_clk_monitor_chk.sv
// Module: osc_clk_monitor_chk
// Protocol checker for osc_clk_monitor, attached by bind. It samples on the
// backup clock and relates the latched failure and the synchronized enable
// to the interrupt and status outputs.
// Assumes: bound to osc_clk_monitor with its internal fail_w and mon_on_w.
module osc_clk_monitor_chk (
    input logic clk_bak_i,
    input logic rst_n_i,
    input logic irq_o,
    input logic irq_ack_i,
    input logic sel_bak_o,
    input logic fail_q,
    input logic mon_on
);

    // R3: a failure that has been latched for a cycle has moved the switch.
    a_r3_switch_after_fail: assert property (@(posedge clk_bak_i) disable iff (!rst_n_i)
        (fail_q && $past(fail_q)) |-> sel_bak_o);

    // R5: the failure stays latched while the monitor is enabled.
    a_r5_fail_sticky: assert property (@(posedge clk_bak_i) disable iff (!rst_n_i)
        (fail_q && mon_on) |=> fail_q);

    // R6: the interrupt level holds until acknowledged.
    a_r6_irq_held: assert property (@(posedge clk_bak_i) disable iff (!rst_n_i)
        (irq_o && !irq_ack_i && mon_on) |=> irq_o);

    // R6: the interrupt only rises together with a new failure.
    a_r6_irq_new_fail: assert property (@(posedge clk_bak_i) disable iff (!rst_n_i)
        $rose(irq_o) |-> $rose(fail_q));

    // R7: a disabled monitor clears the interrupt and the failure.
    a_r7_disabled_quiet: assert property (@(posedge clk_bak_i) disable iff (!rst_n_i)
        !mon_on |=> (!irq_o && !fail_q));

endmodule

bind osc_clk_monitor osc_clk_monitor_chk chk_i (
    .clk_bak_i (clk_bak_i),
    .rst_n_i   (rst_n_i),
    .irq_o     (irq_o),
    .irq_ack_i (irq_ack_i),
    .sel_bak_o (sel_bak_o),
    .fail_q    (fail_w),
    .mon_on    (mon_on_w)
);

// File: tb/osc_clk_monitor_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, checked in the task itself.
module osc_clk_monitor_tb_top;

    localparam int unsigned THRESH = 8;

    logic clk_pri   = 1'b0;
    logic clk_bak   = 1'b0;
    logic rst_n     = 1'b0;
    logic mon_en    = 1'b1;
    logic irq_ack   = 1'b0;
    logic pri_run   = 1'b1;
    logic cpu_clk;
    logic irq;
    logic sel_bak;

    int checks = 0;
    int errors = 0;

    // Width monitor state.
    logic    meas_en   = 1'b0;
    realtime last_edge = 0.0;
    realtime min_width = 1000.0;

    osc_clk_monitor #(
        .PRI_DIV_W   (2),
        .SYNC_STAGES (2),
        .FAIL_THRESH (THRESH)
    ) dut_i (
        .clk_pri_i (clk_pri),
        .clk_bak_i (clk_bak),
        .rst_n_i   (rst_n),
        .mon_en_i  (mon_en),
        .irq_ack_i (irq_ack),
        .cpu_clk_o (cpu_clk),
        .irq_o     (irq),
        .sel_bak_o (sel_bak)
    );

    // Backup clock: 250 MHz.
    initial forever #2 clk_bak = ~clk_bak;

    // Primary clock: 6 ns period, stoppable.
    initial forever begin
        #3;
        if (pri_run) clk_pri = ~clk_pri;
    end

    // Records the shortest phase of cpu_clk while measurement is on.
    always @(cpu_clk) begin
        if (meas_en && ($realtime - last_edge) < min_width)
            min_width = $realtime - last_edge;
        last_edge = $realtime;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic bak_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk_bak);
        #1;
    endtask

    // Compares cpu_clk with the expected source at 40 points off any edge.
    task automatic tracks(input bit use_bak, input string req, input string what);
        int mism = 0;
        @(posedge clk_bak);
        #0.5;
        for (int i = 0; i < 40; i++) begin
            if (cpu_clk !== (use_bak ? clk_bak : clk_pri)) mism++;
            #1;
        end
        chk(mism == 0, req, what, mism, 0);
    endtask

    task automatic stop_pri(input bit lvl);
        if (lvl) @(posedge clk_pri);
        else     @(negedge clk_pri);
        #0.1;
        pri_run = 1'b0;
    endtask

    task automatic do_reset();
        pri_run = 1'b1;
        rst_n   = 1'b0;
        bak_cycles(12);
        // R1: quiet outputs and primary clock during reset.
        chk(irq == 1'b0, "R1", "irq in reset", irq, 0);
        chk(sel_bak == 1'b0, "R1", "sel_bak in reset", sel_bak, 0);
        tracks(1'b0, "R1", "cpu_clk mismatches in reset");
        @(negedge clk_bak);
        rst_n = 1'b1;
        bak_cycles(2);
    endtask

    // R2: a healthy primary clock never trips the monitor.
    task automatic t_healthy();
        bak_cycles(200);
        chk(irq == 1'b0, "R2", "irq with healthy clock", irq, 0);
        chk(sel_bak == 1'b0, "R2", "sel_bak with healthy clock", sel_bak, 0);
        tracks(1'b0, "R2", "cpu_clk mismatches healthy");
    endtask

    // R3, R4, R6, R8: primary stops at a given level.
    task automatic t_stop(input bit lvl, input bit do_irq);
        min_width = 1000.0;
        meas_en   = 1'b1;
        stop_pri(lvl);
        bak_cycles(4);
        chk(sel_bak == 1'b0 && irq == 1'b0, "R3", "early switch", sel_bak, 0);
        bak_cycles(THRESH + 4);
        chk(irq == 1'b1, "R3", "irq after stop", irq, 1);
        chk(sel_bak == 1'b1, "R3", "sel_bak after stop", sel_bak, 1);
        bak_cycles(4);
        meas_en = 1'b0;
        chk(min_width > 1.9, "R8", "shortest phase x10 ns",
            int'(min_width * 10.0), 20);
        tracks(1'b1, "R4", "cpu_clk mismatches on backup");
        if (do_irq) begin
            bak_cycles(10);
            chk(irq == 1'b1, "R6", "irq held without ack", irq, 1);
            @(negedge clk_bak);
            irq_ack = 1'b1;
            @(negedge clk_bak);
            irq_ack = 1'b0;
            #1;
            chk(irq == 1'b0, "R6", "irq after ack", irq, 0);
            bak_cycles(30);
            chk(irq == 1'b0, "R6", "irq not raised again", irq, 0);
        end
    endtask

    // R5: a resumed primary clock does not undo the switch; reset does.
    task automatic t_sticky();
        pri_run = 1'b1;
        bak_cycles(60);
        chk(sel_bak == 1'b1, "R5", "sel_bak after resume", sel_bak, 1);
        tracks(1'b1, "R5", "cpu_clk mismatches after resume");
        do_reset();
        bak_cycles(10);
        chk(sel_bak == 1'b0, "R5", "sel_bak after reset", sel_bak, 0);
        tracks(1'b0, "R5", "cpu_clk mismatches after reset");
    endtask

    // R7: the enable pin low disables supervision and clears a failure.
    task automatic t_disable();
        // Latched failure, then disable.
        stop_pri(1'b0);
        bak_cycles(THRESH + 10);
        chk(sel_bak == 1'b1, "R7", "precondition sel_bak", sel_bak, 1);
        @(negedge clk_bak);
        mon_en = 1'b0;
        bak_cycles(4);
        chk(sel_bak == 1'b0 && irq == 1'b0, "R7", "failure cleared", sel_bak, 0);
        pri_run = 1'b1;
        tracks(1'b0, "R7", "cpu_clk mismatches disabled");
        // Disabled and primary stops: nothing happens.
        stop_pri(1'b1);
        bak_cycles(THRESH * 5);
        chk(irq == 1'b0, "R7", "irq while disabled", irq, 0);
        chk(sel_bak == 1'b0, "R7", "sel_bak while disabled", sel_bak, 0);
        tracks(1'b0, "R7", "cpu_clk mismatches disabled stopped");
        // Re-enable on a healthy clock: no switch.
        pri_run = 1'b1;
        bak_cycles(4);
        mon_en = 1'b1;
        bak_cycles(60);
        chk(sel_bak == 1'b0 && irq == 1'b0, "R7", "re-enable healthy", sel_bak, 0);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        t_healthy();
        t_stop(1'b0, 1'b1);
        t_sticky();
        t_stop(1'b1, 1'b0);
        do_reset();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule